// File: doc/BRIEF.md
# Non-Overlapping Two-Phase Clock Generator

This block turns one fast reference clock into two phase clocks that are never high together. Each period has four intervals: phase one high, a dead time with both outputs low, phase two high, and a second dead time. Every interval lasts a set number of reference cycles, and each count comes from its own configuration input. The dead time gives downstream latch groups a gap that is larger than the clock skew between them.

An enable input starts and stops generation. A new run always begins with phase one. When enable drops, the pulse in progress is not cut short. It completes, its following dead time runs out, and then both outputs stay low. Settings that are out of range raise an error flag, and both phases are held low for as long as the settings stay bad. Both phase outputs come straight from flip-flops, so they cannot glitch.

Top module: `nclk_twophase_gen`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `phase1_o`, `phase2_o` and `cfg_error` are all 0.
- R2: `phase1_o` and `phase2_o` are never 1 in the same cycle.
- R3: Enable is sampled on a clock edge. If it is sampled high while the block is idle, `phase1_o` rises on that same edge. Each phase-one pulse lasts exactly `cfg_width1` cycles.
- R4: Each phase-two pulse lasts exactly `cfg_width2` cycles.
- R5: Between the end of any phase pulse and the start of the other phase, both outputs are low for exactly `cfg_dead` cycles.
- R6: The pulses strictly alternate: phase one, dead time, phase two, dead time, and then phase one again while enable stays high. No other pulse ever appears.
- R7: `cfg_error` becomes 1 one cycle after any of these holds: `cfg_width1 < MIN_PULSE`, `cfg_width2 < MIN_PULSE`, or `cfg_dead == 0`. It becomes 0 one cycle after all three settings are valid again.
- R8: While `cfg_error` is 1, both phase outputs are 0, whatever the enable level. A pulse in progress is cut off on the cycle `cfg_error` rises.
- R9: If enable drops during a pulse, that pulse still lasts its full width. It is followed by a full dead time, and after that no further pulse starts while enable stays low.
- R10: After a stop, the next run starts with phase one. At least `cfg_dead` low cycles separate it from the last pulse of the previous run.
- R11: The smallest legal settings are accepted: pulse widths equal to `MIN_PULSE` and a dead time of 1 leave `cfg_error` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Starts generation when high; a drop triggers a clean stop |
| cfg_width1 | input | CNT_W | Phase-one high time, in reference cycles |
| cfg_width2 | input | CNT_W | Phase-two high time, in reference cycles |
| cfg_dead | input | CNT_W | Dead time between phases, in reference cycles |
| phase1_o | output | 1 | Phase-one clock, driven from a flip-flop |
| phase2_o | output | 1 | Phase-two clock, driven from a flip-flop |
| cfg_error | output | 1 | High when the settings are out of range |

## Verification
The bench builds the block with `CNT_W = 5` and `MIN_PULSE = 3`. With these values the largest count, 31, can be used both as a pulse width and as a dead time within a short run. A width of 2 is then just below the minimum, so the error boundary is tested at a value that is not zero. The runs use the minimum legal widths with a one-cycle dead time, mixed and uneven widths, and stops placed inside each phase. One more run has a pulse aborted mid-way by a bad setting. Together these cover the shortest and the longest interval that each counter can produce.

// File: rtl/nclk_pkg.sv
package nclk_pkg;

    // Sequencer states: two pulse intervals, each followed by a gap interval.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ONE  = 3'd1,
        PH_GAP1 = 3'd2,
        PH_TWO  = 3'd3,
        PH_GAP2 = 3'd4
    } phase_state_e;

    typedef struct packed {
        logic ph1;
        logic ph2;
    } phase_pair_t;

    // Output levels that belong to a state.
    function automatic phase_pair_t drive_of(phase_state_e s);
        phase_pair_t r;
        r.ph1 = (s == PH_ONE);
        r.ph2 = (s == PH_TWO);
        return r;
    endfunction

    function automatic logic is_gap(phase_state_e s);
        return (s == PH_GAP1) || (s == PH_GAP2);
    endfunction

endpackage

// File: rtl/nclk_cfg_check.sv
module nclk_cfg_check #(
    parameter int CNT_W     = 8,
    parameter int MIN_PULSE = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] len1,
    input  logic [CNT_W-1:0] len2,
    input  logic [CNT_W-1:0] gap_len,
    output logic             bad,
    output logic             err_q
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_PULSE);

    logic width_bad;

    // A floor of one or less reduces to a test for zero.
    generate
        if (MIN_PULSE > 1) begin : g_floor_cmp
            always_comb width_bad = (len1 < MIN_V) || (len2 < MIN_V);
        end else begin : g_floor_zero
            always_comb width_bad = (len1 == '0) || (len2 == '0);
        end
    endgenerate

    always_comb bad = width_bad || (gap_len == '0);

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= bad;
    end
endmodule

// File: rtl/nclk_phase_seq.sv
module nclk_phase_seq
    import nclk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             halt,
    input  logic [CNT_W-1:0] len1,
    input  logic [CNT_W-1:0] len2,
    input  logic [CNT_W-1:0] gap_len,
    output phase_state_e     state_q,
    output phase_state_e     state_d
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             last;

    assign last = (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q - ONE;
        if (halt) begin
            state_d = PH_IDLE;
            cnt_d   = '0;
        end else begin
            case (state_q)
                PH_IDLE: begin
                    cnt_d = '0;
                    if (run_en) begin
                        state_d = PH_ONE;
                        cnt_d   = len1 - ONE;
                    end
                end
                PH_ONE: if (last) begin
                    state_d = PH_GAP1;
                    cnt_d   = gap_len - ONE;
                end
                PH_GAP1: if (last) begin
                    if (run_en) begin
                        state_d = PH_TWO;
                        cnt_d   = len2 - ONE;
                    end else begin
                        state_d = PH_IDLE;
                        cnt_d   = '0;
                    end
                end
                PH_TWO: if (last) begin
                    state_d = PH_GAP2;
                    cnt_d   = gap_len - ONE;
                end
                PH_GAP2: if (last) begin
                    if (run_en) begin
                        state_d = PH_ONE;
                        cnt_d   = len1 - ONE;
                    end else begin
                        state_d = PH_IDLE;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = PH_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // R3: a pulse is never cut short while the settings are valid.
    assert_pulse_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (!halt && state_q == PH_ONE && !last) |=> (state_q == PH_ONE));

    // R6: after the first gap comes phase two when running.
    assert_order_R6: assert property (@(posedge clk) disable iff (rst)
        (!halt && state_q == PH_GAP1 && last && run_en) |=> (state_q == PH_TWO));

    // R9: a gap that ends with enable low returns to idle.
    assert_gap_stop_R9: assert property (@(posedge clk) disable iff (rst)
        (!halt && is_gap(state_q) && last && !run_en) |=> (state_q == PH_IDLE));

    // R10: idle is left only through enable.
    assert_idle_wait_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_IDLE && !run_en) |=> (state_q == PH_IDLE));
endmodule

// File: rtl/nclk_phase_out.sv
module nclk_phase_out
    import nclk_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  phase_state_e state_d,
    output phase_pair_t  pair_q
);
    // Outputs are registered from the next state so that they line up with it.
    always_ff @(posedge clk) begin
        if (rst) pair_q <= '0;
        else     pair_q <= drive_of(state_d);
    end
endmodule

// File: rtl/nclk_twophase_gen.sv
module nclk_twophase_gen
    import nclk_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int MIN_PULSE = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [CNT_W-1:0] cfg_width1,
    input  logic [CNT_W-1:0] cfg_width2,
    input  logic [CNT_W-1:0] cfg_dead,
    output logic             phase1_o,
    output logic             phase2_o,
    output logic             cfg_error
);
    logic         cfg_bad;
    phase_state_e seq_q, seq_d;
    phase_pair_t  pair;

    nclk_cfg_check #(.CNT_W(CNT_W), .MIN_PULSE(MIN_PULSE)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .len1   (cfg_width1),
        .len2   (cfg_width2),
        .gap_len(cfg_dead),
        .bad    (cfg_bad),
        .err_q  (cfg_error)
    );

    nclk_phase_seq #(.CNT_W(CNT_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .run_en (enable),
        .halt   (cfg_bad),
        .len1   (cfg_width1),
        .len2   (cfg_width2),
        .gap_len(cfg_dead),
        .state_q(seq_q),
        .state_d(seq_d)
    );

    nclk_phase_out u_out (
        .clk    (clk),
        .rst    (rst),
        .state_d(seq_d),
        .pair_q (pair)
    );

    assign phase1_o = pair.ph1;
    assign phase2_o = pair.ph2;

    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
        !(phase1_o && phase2_o));

    assert_err_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_error |-> (!phase1_o && !phase2_o));

    assert_zero_dead_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_dead == '0) |=> cfg_error);

    assert_gap_before_two_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(phase2_o) |-> !$past(phase1_o));
endmodule

// File: tb/nclk_twophase_gen_bench.sv
`timescale 1ns/1ps
module nclk_twophase_gen_bench;
    localparam int CW = 5;
    localparam int MP = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic [CW-1:0] w1 = CW'(3);
    logic [CW-1:0] w2 = CW'(3);
    logic [CW-1:0] dd = CW'(1);
    logic ph1, ph2, err;

    always #2 clk = ~clk;

    nclk_twophase_gen #(.CNT_W(CW), .MIN_PULSE(MP)) u_nclk_twophase_gen (
        .clk(clk), .rst(rst), .enable(enable),
        .cfg_width1(w1), .cfg_width2(w2), .cfg_dead(dd),
        .phase1_o(ph1), .phase2_o(ph2), .cfg_error(err)
    );

    int checks = 0;
    int errors = 0;

    // kind: 1 = phase-one pulse, 2 = phase-two pulse, 0 = low gap
    typedef struct {
        int    kind;
        int    width;
        bit    atleast;
        string req;
    } exp_t;
    exp_t expq[$];

    bit skip_mon   = 1'b1;
    bit first_sess = 1'b1;
    int last_dead  = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(int kind, int width, bit atleast, string req);
        exp_t e;
        e.kind = kind; e.width = width; e.atleast = atleast; e.req = req;
        expq.push_back(e);
    endtask

    task automatic record(int kind, int w);
        exp_t e;
        if (expq.size() == 0) begin
            chk(1'b0, "R6", "unexpected interval kind", kind, -1);
        end else begin
            e = expq.pop_front();
            chk(kind == e.kind, e.req, "interval kind", kind, e.kind);
            if (e.atleast) chk(w >= e.width, e.req, "idle gap length", w, e.width);
            else           chk(w == e.width, e.req, "interval length", w, e.width);
        end
    endtask

    // Monitor: run-length encodes the outputs and compares with the queue.
    logic [1:0] prev_lv = 2'b00;
    int run_len = 0;
    bit seen = 1'b0;
    always @(posedge clk) begin
        #1;
        if (rst || skip_mon) begin
            prev_lv = {ph1, ph2};
            run_len = 1;
            seen    = 1'b0;
        end else begin
            chk(!(ph1 && ph2), "R2", "both phases high", {ph1, ph2}, 0);
            if ({ph1, ph2} != prev_lv) begin
                if (prev_lv != 2'b00) record((prev_lv == 2'b10) ? 1 : 2, run_len);
                else if (seen)        record(0, run_len);
                if ({ph1, ph2} != 2'b00) seen = 1'b1;
                prev_lv = {ph1, ph2};
                run_len = 1;
            end else begin
                run_len++;
            end
        end
    end

    // Driver: one run of n full periods, then a stop in phase two or in phase one.
    task automatic session(int p1, int p2, int d, int n, bit stop_in_one);
        int t;
        t = p1 + p2 + 2 * d;
        if (!first_sess) push(0, last_dead, 1'b1, "R10");
        first_sess = 1'b0;
        for (int i = 0; i < n; i++) begin
            push(1, p1, 1'b0, "R3");
            push(0, d, 1'b0, "R5");
            push(2, p2, 1'b0, "R4");
            if (i < n - 1 || stop_in_one) push(0, d, 1'b0, "R5");
        end
        if (stop_in_one) push(1, p1, 1'b0, "R9");
        @(negedge clk);
        w1 = CW'(p1); w2 = CW'(p2); dd = CW'(d);
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        chk(ph1 == 1'b1, "R3", "phase one rises on the enable edge", ph1, 1);
        if (stop_in_one) repeat (n * t) @(negedge clk);
        else             repeat ((n - 1) * t + p1 + d) @(negedge clk);
        enable = 1'b0;
        repeat (t + 4) @(negedge clk);
        chk(!ph1 && !ph2, "R9", "outputs low after stop", {ph1, ph2}, 0);
        last_dead = d;
    endtask

    task automatic err_case(int p1, int p2, int d, string what);
        @(negedge clk);
        w1 = CW'(p1); w2 = CW'(p2); dd = CW'(d);
        @(negedge clk);
        chk(err == 1'b1, "R7", what, err, 1);
        enable = 1'b1;
        repeat (5) begin
            @(negedge clk);
            chk(!ph1 && !ph2, "R8", "outputs while settings bad", {ph1, ph2}, 0);
        end
        enable = 1'b0;
        @(negedge clk);
        w1 = CW'(5); w2 = CW'(5); dd = CW'(2);
        @(negedge clk);
        chk(err == 1'b0, "R7", "flag clears after fix", err, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!ph1 && !ph2 && !err, "R1", "outputs during reset", {ph1, ph2, err}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!ph1 && !ph2 && !err, "R1", "outputs after reset", {ph1, ph2, err}, 0);
        skip_mon = 1'b0;

        // R11: minimum legal settings
        w1 = CW'(MP); w2 = CW'(MP); dd = CW'(1);
        repeat (2) @(negedge clk);
        chk(err == 1'b0, "R11", "minimum settings flagged", err, 0);
        session(MP, MP, 1, 3, 1'b0);
        session(5, 7, 2, 2, 1'b1);

        err_case(2, 5, 2, "width1 below minimum");
        err_case(5, 2, 2, "width2 below minimum");
        err_case(5, 5, 0, "zero dead time");

        session(31, 4, 31, 1, 1'b0);

        // R8: a bad setting aborts a pulse in flight
        skip_mon = 1'b1;
        @(negedge clk);
        w1 = CW'(5); w2 = CW'(7); dd = CW'(2);
        @(negedge clk);
        enable = 1'b1;
        repeat (3) @(negedge clk);
        chk(ph1 == 1'b1, "R3", "phase one mid-pulse", ph1, 1);
        dd = CW'(0);
        @(negedge clk);
        chk(!ph1 && !ph2, "R8", "pulse cut by bad setting", {ph1, ph2}, 0);
        chk(err == 1'b1, "R7", "flag on zero dead time", err, 1);
        enable = 1'b0;
        @(negedge clk);
        dd = CW'(2);
        repeat (4) @(negedge clk);
        chk(err == 1'b0, "R7", "flag clears", err, 0);
        skip_mon   = 1'b0;
        first_sess = 1'b1;

        session(4, 9, 3, 2, 1'b0);

        repeat (10) @(negedge clk);
        chk(expq.size() == 0, "R6", "missing intervals", expq.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule